// File: doc/BRIEF.md
# Configurable GPIO Port with Change Interrupt

This block is one general-purpose I/O port of `NPINS` pins, eight by default. A host reaches it through a simple register bus: a write strobe, a read strobe, an address, write data and registered read data. The pin levels pass through a two-flop synchronizer. The block keeps the value the host wants to drive apart from the level it reads back, so a pin can be driven and read at the same time (quasi-bidirectional use). Each pin can invert its read-back value, can take a PWM waveform in place of its output bit, and has its own drive mode. For every pin the block produces the pad controls: a driven value, an output enable, a weak-pull enable with its direction, and a slow-slew flag.

An edge in either direction on a synchronized input sets a sticky status bit. Any read of the status register clears all of its bits. Each pin has a mask bit, where 1 blocks that pin, and the interrupt line is active low. The register bus is a control path, so it uses plain strobes without valid/ready. A read strobe returns data on the next cycle, and the bus has no back-pressure.

Top module: `gpio_port`

## Requirements
- R1: The output register (address 0, reset all ones) holds the value written to it. Reading address 1 returns the pad level, synchronized through two flops and XORed with the inversion register. A read of address 1 made three or more clock edges after the pad settles shows that level, whatever the output register holds.
- R2: Each 1 bit in the inversion register (address 2) inverts the matching bit returned from address 1.
- R3: A change of a synchronized input in either direction sets the matching bit of the status register (address 4). The bit is set three clock edges after the pad changes.
- R4: Any read of address 4 returns the status value held before that read's clock edge, and the same edge clears every status bit.
- R5: A change that is detected on the same clock edge as a status read is kept in the status register after the clear.
- R6: `irq_n` is low while any status bit is set whose mask bit (address 3) is 0. A mask bit of 1 stops that pin from driving the interrupt line, but its status bit is still recorded.
- R7: Pin i takes its drive mode from bits [2:0] of address 8+i. Let d be the pin's source bit; `pad_out` always equals d. The modes are: 0 pull-up (enable = !d, pull on, pull up); 1 pull-down (enable = d, pull on, pull down); 2 open-drain high (enable = d); 3 open-drain low (enable = !d); 4 strong fast (enable = 1); 5 strong slow (enable = 1, slow = 1); 6 and 7 high impedance (enable = 0). The pull and slow flags are 0 in every mode that does not set them.
- R8: After reset every drive mode is 0 (pull-up), the output register is all ones, the inversion, mask, PWM-select and status registers are zero, and `irq_n` is high.
- R9: When a bit of the PWM-select register (address 5) is 1, that pin's source bit d is `pwm_in` for that pin. When the bit is 0, d is the output register bit.
- R10: Writes to addresses 1 and 4 have no effect. Reads of unmapped addresses (6, 7) return 0. Reads of address 8+i return the mode of pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | $clog2(8+NPINS) | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Read data, valid the cycle after `reg_rd` |
| pwm_in | input | NPINS | PWM waveforms, one per pin |
| pad_in | input | NPINS | Pad input levels, asynchronous |
| pad_out | output | NPINS | Value driven when enabled |
| pad_oe | output | NPINS | Driver enable |
| pad_pull_en | output | NPINS | Weak pull enable |
| pad_pull_up | output | NPINS | Pull direction, 1 = up |
| pad_slow | output | NPINS | Slow slew select |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The pad controls are swept over all eight mode codes, each with all-zero, all-one and two checkerboard source patterns, once from the output register and once with half the pins taken from PWM. This separates an error in a mode from an error in the source selection. All 256 pad input values are read back under a fixed inversion pattern while the output register holds the opposite level, which separates the input path from the output register. The interrupt is tried with a single toggled pin for every pin, masked and unmasked, and with a change that lands on the same edge as a status read. These cases separate the set, clear and mask paths.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [2:0] {
    DM_PULL_UP     = 3'd0,
    DM_PULL_DN     = 3'd1,
    DM_OD_HI       = 3'd2,
    DM_OD_LO       = 3'd3,
    DM_STRONG      = 3'd4,
    DM_STRONG_SLOW = 3'd5,
    DM_HIZ         = 3'd6,
    DM_HIZ_ALT     = 3'd7
  } drive_mode_e;

  localparam int unsigned REG_OUT   = 0;
  localparam int unsigned REG_IN    = 1;
  localparam int unsigned REG_INV   = 2;
  localparam int unsigned REG_MASK  = 3;
  localparam int unsigned REG_STAT  = 4;
  localparam int unsigned REG_PSEL  = 5;
  localparam int unsigned MODE_BASE = 8;
  localparam int unsigned MODE_W    = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_sync,
  input  logic         rd_clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] stat,
  output logic         irq_n
);
  logic [W-1:0] prev_q, stat_q, chg;

  assign chg = in_sync ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= in_sync;
      stat_q <= (rd_clr ? '0 : stat_q) | chg;
    end
  end

  assign stat  = stat_q;
  assign irq_n = ~|(stat_q & ~mask);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && chg == '0) |=> (stat_q == '0));
  assert_change_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |=> ((stat_q & $past(chg)) == $past(chg)));
  assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> irq_n);
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0][MODE_W-1:0] mode,
  input  logic [W-1:0]             out_bits,
  input  logic [W-1:0]             pwm_sel,
  input  logic [W-1:0]             pwm_in,
  output logic [W-1:0]             pad_out,
  output logic [W-1:0]             pad_oe,
  output logic [W-1:0]             pad_pull_en,
  output logic [W-1:0]             pad_pull_up,
  output logic [W-1:0]             pad_slow
);
  logic [W-1:0] src;

  assign src     = (pwm_sel & pwm_in) | (~pwm_sel & out_bits);
  assign pad_out = src;

  always_comb begin
    pad_oe      = '0;
    pad_pull_en = '0;
    pad_pull_up = '0;
    pad_slow    = '0;
    for (int i = 0; i < int'(W); i++) begin
      case (drive_mode_e'(mode[i]))
        DM_PULL_UP:     begin pad_oe[i] = ~src[i]; pad_pull_en[i] = 1'b1; pad_pull_up[i] = 1'b1; end
        DM_PULL_DN:     begin pad_oe[i] = src[i];  pad_pull_en[i] = 1'b1; end
        DM_OD_HI:       pad_oe[i] = src[i];
        DM_OD_LO:       pad_oe[i] = ~src[i];
        DM_STRONG:      pad_oe[i] = 1'b1;
        DM_STRONG_SLOW: begin pad_oe[i] = 1'b1; pad_slow[i] = 1'b1; end
        default:        pad_oe[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [$clog2(MODE_BASE+NPINS)-1:0]  reg_addr,
  input  logic                                reg_wr,
  input  logic                                reg_rd,
  input  logic [NPINS-1:0]                    reg_wdata,
  output logic [NPINS-1:0]                    reg_rdata,
  input  logic [NPINS-1:0]                    pwm_in,
  input  logic [NPINS-1:0]                    pad_in,
  output logic [NPINS-1:0]                    pad_out,
  output logic [NPINS-1:0]                    pad_oe,
  output logic [NPINS-1:0]                    pad_pull_en,
  output logic [NPINS-1:0]                    pad_pull_up,
  output logic [NPINS-1:0]                    pad_slow,
  output logic                                irq_n
);
  localparam int unsigned AW = $clog2(MODE_BASE + NPINS);
  localparam int unsigned DW = NPINS;

  logic [DW-1:0]             out_q, inv_q, mask_q, psel_q;
  logic [DW-1:0][MODE_W-1:0] mode_q;
  logic [DW-1:0]             in_sync, stat, rd_mux;
  logic                      stat_rd;

  assign stat_rd = reg_rd && (reg_addr == AW'(REG_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '1;
      inv_q  <= '0;
      mask_q <= '0;
      psel_q <= '0;
      mode_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == AW'(REG_OUT))  out_q  <= reg_wdata;
      if (reg_addr == AW'(REG_INV))  inv_q  <= reg_wdata;
      if (reg_addr == AW'(REG_MASK)) mask_q <= reg_wdata;
      if (reg_addr == AW'(REG_PSEL)) psel_q <= reg_wdata;
      for (int i = 0; i < int'(NPINS); i++) begin
        if (reg_addr == AW'(MODE_BASE + i)) mode_q[i] <= reg_wdata[MODE_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == AW'(REG_OUT))  rd_mux = out_q;
    if (reg_addr == AW'(REG_IN))   rd_mux = in_sync ^ inv_q;
    if (reg_addr == AW'(REG_INV))  rd_mux = inv_q;
    if (reg_addr == AW'(REG_MASK)) rd_mux = mask_q;
    if (reg_addr == AW'(REG_STAT)) rd_mux = stat;
    if (reg_addr == AW'(REG_PSEL)) rd_mux = psel_q;
    for (int i = 0; i < int'(NPINS); i++) begin
      if (reg_addr == AW'(MODE_BASE + i)) rd_mux = DW'(mode_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  gpio_sync #(.W(DW)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(in_sync)
  );

  gpio_chg_irq #(.W(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .in_sync(in_sync), .rd_clr(stat_rd),
    .mask(mask_q), .stat(stat), .irq_n(irq_n)
  );

  gpio_pad_ctl #(.W(DW)) u_pad (
    .mode(mode_q), .out_bits(out_q), .pwm_sel(psel_q), .pwm_in(pwm_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .pad_slow(pad_slow)
  );

  assert_out_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(REG_OUT)) |=> (out_q == $past(reg_wdata)));

  for (genvar g = 0; g < int'(NPINS); g++) begin : g_pin_chk
    assert_hiz_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[g][2:1] == 2'b11) |-> (!pad_oe[g] && !pad_pull_en[g]));
    assert_strong_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[g][2:1] == 2'b10) |-> pad_oe[g]);
    assert_pwm_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
      psel_q[g] |-> (pad_out[g] == pwm_in[g]));
  end
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int N  = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [N-1:0]  reg_wdata = '0, pwm_in = '0, pad_in = '0;
  logic [N-1:0]  reg_rdata, pad_out, pad_oe, pad_pull_en, pad_pull_up, pad_slow;
  logic          irq_n;
  int            n_chk = 0, n_fail = 0;
  logic [N-1:0]  rv;

  always #10 clk = ~clk;

  gpio_port #(.NPINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_in(pwm_in), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .pad_slow(pad_slow), .irq_n(irq_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [N-1:0] d);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [N-1:0] d);
    reg_addr = AW'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Pad expectations taken from the mode table in R7, source per R9
  task automatic check_pads(input logic [2:0] m, input logic [N-1:0] d, input string req);
    logic [N-1:0] eoe, epe, epu, esl;
    eoe = '0; epe = '0; epu = '0; esl = '0;
    case (m)
      3'd0: begin eoe = ~d; epe = '1; epu = '1; end
      3'd1: begin eoe = d;  epe = '1; end
      3'd2: eoe = d;
      3'd3: eoe = ~d;
      3'd4: eoe = '1;
      3'd5: begin eoe = '1; esl = '1; end
      default: eoe = '0;
    endcase
    check(pad_out == d, req, pad_out, d);
    check(pad_oe == eoe, req, pad_oe, eoe);
    check(pad_pull_en == epe, req, pad_pull_en, epe);
    check(pad_pull_up == epu, req, pad_pull_up, epu);
    check(pad_slow == esl, req, pad_slow, esl);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [N-1:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h5A; pats[3] = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    check(irq_n == 1'b1, "R8 irq_n", irq_n, 1);
    check_pads(3'd0, 8'hFF, "R8 pads");
    rd(0, rv); check(rv == 8'hFF, "R8 out reg", rv, 8'hFF);
    rd(2, rv); check(rv == 8'h00, "R8 inv reg", rv, 0);
    rd(3, rv); check(rv == 8'h00, "R8 mask reg", rv, 0);
    rd(4, rv); check(rv == 8'h00, "R8 status", rv, 0);
    rd(5, rv); check(rv == 8'h00, "R8 psel reg", rv, 0);
    for (int i = 0; i < N; i++) begin
      rd(8 + i, rv); check(rv == 8'h00, "R8 mode", rv, 0);
    end

    // R7 and R9 sweep: all modes, four patterns, with and without PWM
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < N; i++) wr(8 + i, N'(m));
      rd(8 + 3, rv); check(rv == N'(m), "R10 mode readback", rv, m);
      for (int p = 0; p < 4; p++) begin
        wr(5, 8'h00); wr(0, pats[p]); pwm_in = ~pats[p];
        @(negedge clk);
        check_pads(3'(m), pats[p], "R7 out-reg source");
        wr(5, 8'h0F);
        @(negedge clk);
        check_pads(3'(m), (pats[p] & 8'hF0) | (~pats[p] & 8'h0F), "R9 pwm source");
      end
    end
    wr(5, 8'h00);
    for (int i = 0; i < N; i++) wr(8 + i, 8'd0);

    // R1 and R2: full input sweep, output register opposite, inversion 3C
    wr(3, 8'hFF);
    wr(2, 8'h3C);
    for (int v = 0; v < 256; v++) begin
      pad_in = N'(v);
      wr(0, ~N'(v));
      settle();
      rd(1, rv);
      check(rv == (N'(v) ^ 8'h3C), "R1 R2 input readback", rv, N'(v) ^ 8'h3C);
    end
    rd(0, rv); check(rv == 8'h00, "R1 out reg held", rv, 0);
    wr(2, 8'h00);
    pad_in = 8'h0F; wr(0, 8'hFF); settle();
    rd(1, rv); check(rv == 8'h0F, "R1 quasi-bidir read", rv, 8'h0F);

    // R10 ignored writes and unmapped reads
    wr(1, 8'hAA); rd(1, rv); check(rv == 8'h0F, "R10 write to input ignored", rv, 8'h0F);
    rd(4, rv);
    wr(3, 8'h00);
    wr(4, 8'hFF); @(negedge clk);
    check(irq_n == 1'b1, "R10 write to status ignored irq", irq_n, 1);
    rd(4, rv); check(rv == 8'h00, "R10 write to status ignored", rv, 0);
    rd(6, rv); check(rv == 8'h00, "R10 unmapped 6", rv, 0);
    rd(7, rv); check(rv == 8'h00, "R10 unmapped 7", rv, 0);

    // R3 R4 R6: each pin toggled, unmasked then masked
    for (int k = 0; k < N; k++) begin
      for (int mk = 0; mk < 2; mk++) begin
        wr(3, mk != 0 ? N'(1 << k) : 8'h00);
        rd(4, rv);
        pad_in = pad_in ^ N'(1 << k);
        settle();
        check(irq_n == (mk != 0), "R6 irq after change", irq_n, mk != 0);
        rd(4, rv); check(rv == N'(1 << k), "R3 status bit", rv, N'(1 << k));
        check(irq_n == 1'b1, "R4 irq after clear", irq_n, 1);
        rd(4, rv); check(rv == 8'h00, "R4 status cleared", rv, 0);
      end
    end

    // R6 mixed mask: only unmasked bits drive irq
    wr(3, 8'hF0); rd(4, rv);
    pad_in = pad_in ^ 8'h10; settle();
    check(irq_n == 1'b1, "R6 masked bit4", irq_n, 1);
    pad_in = pad_in ^ 8'h01; settle();
    check(irq_n == 1'b0, "R6 unmasked bit0", irq_n, 0);
    rd(4, rv); check(rv == 8'h11, "R3 two bits", rv, 8'h11);

    // R5 change on the same edge as the status read
    wr(3, 8'h00); rd(4, rv);
    pad_in = pad_in ^ 8'h04;
    @(negedge clk); @(negedge clk);
    rd(4, rv); check(rv == 8'h00, "R5 read before set", rv, 0);
    check(irq_n == 1'b0, "R5 irq kept", irq_n, 0);
    rd(4, rv); check(rv == 8'h04, "R5 change kept", rv, 8'h04);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule